// File: doc/BRIEF.md
# Mode-Dependent Five-Pin I/O Port Controller

This block manages five device pins from two registers on a small CPU register bus: a direction register and a data register. Each pin is either an input or an output. In the bus-expansion operating modes, the upper four pins carry chip-select strobes instead of port data. The lowest pin carries a refresh strobe whenever refresh is enabled. The chip-select and refresh strobes are made elsewhere and arrive here as inputs. This block only decides which source reaches each pin and whether the pin is driven.

The operating mode is captured while reset is asserted and is held until the next reset. It selects two things: the reset value of the direction register, and whether pins 4 to 1 act as chip selects or as plain I/O. A separate override input lets an external memory controller claim pin 1 as a plain output port. Pin inputs pass through a two-stage synchronizer before the CPU sees them on a data-register read.

Top module: `modal_port_ctrl`

## Requirements
- R1: The mode input is a 3-bit number. Modes 1 to 4 reset the direction bits 4:0 to 5'b10000, so only pin 4 is driven. Every other mode value resets them to 5'b00000. With refresh and override inputs low, this is visible on `pin_oe_o`.
- R2: Bits 7:5 of the data register reset to 1, always read as 1 and ignore writes. Its bits 4:0 reset to 0, so a read of address 1 with all pins low after reset returns 8'hE0.
- R3: The direction register (address 0) is write-only: a read of address 0 always returns 8'hFF, whatever was written.
- R4: A write (`bus_wr_i` high at a rising edge) to address 0 loads the direction bits from `bus_wdata_i[4:0]`, and to address 1 loads the data bits. The new value acts only after that edge. Bits 7:5 of the written word have no effect on either register.
- R5: The expanded modes are 1 to 5. In these modes, with no override, pin k for k = 4 down to 1 drives chip-select input `cs_i[4-k]` when its direction bit is 1. It is undriven (an input) when the bit is 0.
- R6: In an expanded mode, `ras_ovr_i` high forces pin 1 to be driven with data-register bit 1, regardless of its direction bit.
- R7: With `rfsh_en_i` high, in any mode, pin 0 is driven with `rfsh_i` regardless of its direction bit. With `rfsh_en_i` low, pin 0 is driven with data bit 0 exactly when direction bit 0 is 1.
- R8: In modes other than 1 to 5, pins 4 to 1 are plain I/O: driven with their data bit when the direction bit is 1, undriven otherwise. `ras_ovr_i` and `cs_i` have no effect on them.
- R9: A read of address 1 returns, for each bit i in 4:0, the data bit when direction bit i is 1 and the synchronized pin level otherwise. A change on `pin_i` shows up in this read after exactly two rising edges.
- R10: The mode is captured only while `rst_n` is low. A change of `mode_i` after reset has no effect on the pin functions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| mode_i | input | 3 | Operating mode number |
| bus_addr_i | input | 1 | Register select: 0 direction, 1 data |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| cs_i | input | 4 | Chip-select strobes from the bus controller |
| rfsh_en_i | input | 1 | Refresh enable |
| rfsh_i | input | 1 | Refresh strobe |
| ras_ovr_i | input | 1 | External claim of pin 1 as a plain output |
| pin_i | input | 5 | Pin input levels |
| pin_o | output | 5 | Pin output values |
| pin_oe_o | output | 5 | Pin output enables |

## Verification
The hardest situation to reach is the interaction between a mode that was captured earlier and the three override sources. The mode can only enter through reset, so the bench loops over every mode value with a full reset each time. Inside each mode it writes all 32 direction patterns and crosses each with both refresh-enable and override settings and two chip-select patterns. A final step changes `mode_i` without reset and confirms that pin 4 still follows the chip select.

// File: rtl/mpc_pkg.sv
// Package: shared constants, address encoding and mode decoding for the
// mode-dependent port controller. Assumes a 3-bit numeric mode input.
package mpc_pkg;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned PORT_PINS  = 5;
    localparam int unsigned CS_PINS    = 4;
    localparam int unsigned MODE_W     = 3;
    localparam int unsigned SYNC_DEPTH = 2;

    // Register select on the CPU bus
    typedef enum logic {
        ADDR_DIR = 1'b0,
        ADDR_DAT = 1'b1
    } reg_addr_e;

    // True for the bus-expansion modes where chip selects appear on pins
    function automatic logic mode_is_expanded(input logic [MODE_W-1:0] m);
        return (m >= MODE_W'(1)) && (m <= MODE_W'(5));
    endfunction

    // True for the modes whose top pin boots as a driven chip select
    function automatic logic mode_boots_cs0(input logic [MODE_W-1:0] m);
        return (m >= MODE_W'(1)) && (m <= MODE_W'(4));
    endfunction

endpackage

// File: rtl/mpc_regs.sv
// Module: register file of the port controller. Holds the captured mode,
// the direction bits and the data register. Assumes synchronous active-low
// reset; writes land on the rising edge where wr_en is high.
module mpc_regs #(
    parameter int unsigned REG_W  = mpc_pkg::REG_W,
    parameter int unsigned NPINS  = mpc_pkg::PORT_PINS,
    parameter int unsigned MODE_W = mpc_pkg::MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [REG_W-1:0]  dat_q
);
    import mpc_pkg::*;

    localparam logic [REG_W-1:0] RESV_ONES = {REG_W{1'b1}} << NPINS;
    localparam logic [NPINS-1:0] TOP_PIN   = NPINS'(1) << (NPINS - 1);

    logic [NPINS-1:0] dir_boot;

    // Reset value of the direction bits, chosen by the incoming mode
    always_comb begin
        dir_boot = mode_boots_cs0(mode_i) ? TOP_PIN : '0;
    end

    // Capture the mode only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_i;
        end
    end

    // Direction register: mode-dependent reset, low bits writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= dir_boot;
        end else if (wr_en && (wr_addr == ADDR_DIR)) begin
            dir_q <= wdata[NPINS-1:0];
        end
    end

    // Data register: reserved bits forced to one on reset and on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= RESV_ONES;
        end else if (wr_en && (wr_addr == ADDR_DAT)) begin
            dat_q <= (wdata & ~RESV_ONES) | RESV_ONES;
        end
    end

endmodule

// File: rtl/mpc_sync.sv
// Module: multi-stage synchronizer for the pin inputs. Assumes the pins are
// asynchronous to clk; output lags the input by STAGES rising edges.
module mpc_sync #(
    parameter int unsigned W      = mpc_pkg::PORT_PINS,
    parameter int unsigned STAGES = mpc_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pin levels
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= async_i;
            end
        end else begin : g_next
            // Later stages shift the sampled value along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/mpc_pinmux.sv
// Module: per-pin function select. Pin 0 may carry the refresh strobe, the
// top CS_PINS pins may carry chip selects (highest pin = select 0), and the
// lowest chip-select pin may be claimed as a plain output by an override.
// Purely combinational; assumes NPINS = CS_PINS + 1.
module mpc_pinmux #(
    parameter int unsigned NPINS = mpc_pkg::PORT_PINS,
    parameter int unsigned NCS   = mpc_pkg::CS_PINS
) (
    input  logic             expanded,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] dat,
    input  logic [NCS-1:0]   cs_i,
    input  logic             rfsh_en,
    input  logic             rfsh,
    input  logic             ras_ovr,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] dout
);
    localparam int unsigned CS_LO = NPINS - NCS;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        if (p == 0) begin : g_rfsh
            // Refresh strobe outranks the direction bit
            always_comb begin
                if (rfsh_en) begin
                    oe[p]   = 1'b1;
                    dout[p] = rfsh;
                end else begin
                    oe[p]   = dir[p];
                    dout[p] = dat[p];
                end
            end
        end else if (p == CS_LO) begin : g_cs_ras
            // Lowest chip-select pin; override claims it as a port output
            always_comb begin
                if (expanded && ras_ovr) begin
                    oe[p]   = 1'b1;
                    dout[p] = dat[p];
                end else if (expanded) begin
                    oe[p]   = dir[p];
                    dout[p] = cs_i[NPINS-1-p];
                end else begin
                    oe[p]   = dir[p];
                    dout[p] = dat[p];
                end
            end
        end else if (p > CS_LO) begin : g_cs
            // Chip-select pin in expanded modes, plain I/O otherwise
            always_comb begin
                oe[p]   = dir[p];
                dout[p] = expanded ? cs_i[NPINS-1-p] : dat[p];
            end
        end else begin : g_plain
            // Pin without alternate function
            always_comb begin
                oe[p]   = dir[p];
                dout[p] = dat[p];
            end
        end
    end

endmodule

// File: rtl/modal_port_ctrl.sv
// Module: top of the mode-dependent port controller. Joins the register
// file, the pin synchronizer and the pin mux, and forms the read data.
// Assumes a single clock and synchronous active-low reset.
module modal_port_ctrl #(
    parameter int unsigned REG_W  = mpc_pkg::REG_W,
    parameter int unsigned NPINS  = mpc_pkg::PORT_PINS,
    parameter int unsigned NCS    = mpc_pkg::CS_PINS,
    parameter int unsigned MODE_W = mpc_pkg::MODE_W,
    parameter int unsigned SYNC_N = mpc_pkg::SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    input  logic [NCS-1:0]    cs_i,
    input  logic              rfsh_en_i,
    input  logic              rfsh_i,
    input  logic              ras_ovr_i,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe_o
);
    import mpc_pkg::*;

    logic [MODE_W-1:0] mode_q;
    logic [NPINS-1:0]  dir_q;
    logic [REG_W-1:0]  dat_q;
    logic [NPINS-1:0]  pin_sync;
    logic              expanded;

    mpc_regs #(
        .REG_W (REG_W),
        .NPINS (NPINS),
        .MODE_W(MODE_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .wr_en  (bus_wr_i),
        .wr_addr(bus_addr_i),
        .wdata  (bus_wdata_i),
        .mode_q (mode_q),
        .dir_q  (dir_q),
        .dat_q  (dat_q)
    );

    mpc_sync #(
        .W     (NPINS),
        .STAGES(SYNC_N)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (pin_sync)
    );

    // Expanded-mode flag from the captured mode
    always_comb begin
        expanded = mode_is_expanded(mode_q);
    end

    mpc_pinmux #(
        .NPINS(NPINS),
        .NCS  (NCS)
    ) u_mux (
        .expanded(expanded),
        .dir     (dir_q),
        .dat     (dat_q[NPINS-1:0]),
        .cs_i    (cs_i),
        .rfsh_en (rfsh_en_i),
        .rfsh    (rfsh_i),
        .ras_ovr (ras_ovr_i),
        .oe      (pin_oe_o),
        .dout    (pin_o)
    );

    // Read data: direction reads as all ones, data mixes latch and pins
    always_comb begin
        if (bus_addr_i == ADDR_DIR) begin
            bus_rdata_o = '1;
        end else begin
            bus_rdata_o = {dat_q[REG_W-1:NPINS],
                           (dir_q & dat_q[NPINS-1:0]) | (~dir_q & pin_sync)};
        end
    end

endmodule

// File: rtl/mpc_chk.sv
// Module: property checker for the port controller, bound to the top.
// Assumes the default five-pin configuration.
module mpc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_q,
    input logic       expanded,
    input logic       bus_addr_i,
    input logic       bus_wr_i,
    input logic [7:0] bus_wdata_i,
    input logic [7:0] bus_rdata_o,
    input logic [7:0] dat_q,
    input logic       rfsh_en_i,
    input logic       rfsh_i,
    input logic       ras_ovr_i,
    input logic [4:0] pin_o,
    input logic [4:0] pin_oe_o
);
    // R7
    rfsh_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_en_i |-> (pin_oe_o[0] && (pin_o[0] == rfsh_i)));

    // R3
    dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == 1'b0) |-> (bus_rdata_o == 8'hFF));

    // R2
    resv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == 1'b1) |-> (bus_rdata_o[7:5] == 3'b111));

    // R4
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i) |=> (dat_q[4:0] == $past(bus_wdata_i[4:0])));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

    // R6
    ras_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expanded && ras_ovr_i) |-> (pin_oe_o[1] && (pin_o[1] == dat_q[1])));

endmodule

bind modal_port_ctrl mpc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .expanded   (expanded),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .dat_q      (dat_q),
    .rfsh_en_i  (rfsh_en_i),
    .rfsh_i     (rfsh_i),
    .ras_ovr_i  (ras_ovr_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
);

// File: tb/modal_port_ctrl_tb.sv
`timescale 1ns/1ps
module modal_port_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       bus_addr_i = 1'b0;
    logic       bus_wr_i = 1'b0;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o;
    logic [3:0] cs_i = 4'h0;
    logic       rfsh_en_i = 1'b0;
    logic       rfsh_i = 1'b0;
    logic       ras_ovr_i = 1'b0;
    logic [4:0] pin_i = 5'h00;
    logic [4:0] pin_o;
    logic [4:0] pin_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    modal_port_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .bus_addr_i (bus_addr_i),
        .bus_wr_i   (bus_wr_i),
        .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o),
        .cs_i       (cs_i),
        .rfsh_en_i  (rfsh_en_i),
        .rfsh_i     (rfsh_i),
        .ras_ovr_i  (ras_ovr_i),
        .pin_i      (pin_i),
        .pin_o      (pin_o),
        .pin_oe_o   (pin_oe_o)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode_i = m; bus_wr_i = 1'b0;
        rfsh_en_i = 1'b0; ras_ovr_i = 1'b0; pin_i = 5'h00; cs_i = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = v; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    function automatic bit is_exp(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd5);
    endfunction

    function automatic logic [4:0] exp_oe(input logic [2:0] m, input logic [4:0] d,
                                          input logic rf, input logic ras);
        logic [4:0] r;
        r = d;
        if (rf) r[0] = 1'b1;
        if (is_exp(m) && ras) r[1] = 1'b1;
        return r;
    endfunction

    function automatic logic [4:0] exp_out(input logic [2:0] m, input logic [4:0] dv,
                                           input logic [3:0] cs, input logic rf,
                                           input logic rv, input logic ras);
        logic [4:0] r;
        r = dv;
        if (rf) r[0] = rv;
        if (is_exp(m)) begin
            for (int k = 1; k <= 4; k++) r[k] = cs[4-k];
            if (ras) r[1] = dv[1];
        end
        return r;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 8'h00, 8'h01);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] dv, pv, eoe, eo, msk;
        for (int m = 0; m < 8; m++) begin
            do_reset(3'(m));
            #1;
            // R1: reset direction per mode seen on output enables
            chk(pin_oe_o == ((m >= 1 && m <= 4) ? 5'h10 : 5'h00), "R1",
                {3'b0, pin_oe_o}, (m >= 1 && m <= 4) ? 8'h10 : 8'h00);
            bus_addr_i = 1'b0; #1;
            chk(bus_rdata_o == 8'hFF, "R3", bus_rdata_o, 8'hFF);
            bus_addr_i = 1'b1; #1;
            chk(bus_rdata_o == 8'hE0, "R2", bus_rdata_o, 8'hE0);
            for (int d = 0; d < 32; d++) begin
                dv = 5'(d) ^ 5'h0B;
                wr(1'b0, {3'b000, 5'(d)});
                wr(1'b1, {3'b010, dv});
                // R3: direction stays write-only after writes
                bus_addr_i = 1'b0; #1;
                chk(bus_rdata_o == 8'hFF, "R3", bus_rdata_o, 8'hFF);
                // R9, R2, R4: readback mixes latch and synchronized pins
                @(negedge clk);
                pv = ~5'(d) ^ 5'h14;
                pin_i = pv;
                repeat (3) @(negedge clk);
                bus_addr_i = 1'b1; #1;
                chk(bus_rdata_o == {3'b111, (5'(d) & dv) | (~5'(d) & pv)}, "R9",
                    bus_rdata_o, {3'b111, (5'(d) & dv) | (~5'(d) & pv)});
                for (int c = 0; c < 16; c++) begin
                    @(negedge clk);
                    rfsh_en_i = c[0]; ras_ovr_i = c[1]; rfsh_i = c[2];
                    cs_i = c[3] ? 4'h5 : 4'hA;
                    #1;
                    eoe = exp_oe(3'(m), 5'(d), c[0], c[1]);
                    eo  = exp_out(3'(m), dv, cs_i, c[0], c[2], c[1]);
                    msk = eoe;
                    // R5 R6 R7 R8: output enable per mode and overrides
                    chk(pin_oe_o == eoe, is_exp(3'(m)) ? "R5/R6/R7" : "R8/R7",
                        {3'b0, pin_oe_o}, {3'b0, eoe});
                    chk((pin_o & msk) == (eo & msk), is_exp(3'(m)) ? "R5/R6/R7" : "R8/R7",
                        {3'b0, pin_o & msk}, {3'b0, eo & msk});
                end
                rfsh_en_i = 1'b0; ras_ovr_i = 1'b0;
            end
        end

        // R4: write acts only after its edge
        do_reset(3'd7);
        @(negedge clk);
        bus_addr_i = 1'b0; bus_wdata_i = 8'hFF; bus_wr_i = 1'b1;
        #1;
        chk(pin_oe_o == 5'h00, "R4", {3'b0, pin_oe_o}, 8'h00);
        @(negedge clk);
        bus_wr_i = 1'b0; #1;
        chk(pin_oe_o == 5'h1F, "R4", {3'b0, pin_oe_o}, 8'h1F);

        // R9: two-edge synchronizer latency
        wr(1'b0, 8'h00);
        @(negedge clk);
        pin_i = 5'h00;
        repeat (3) @(negedge clk);
        pin_i = 5'h1B;
        bus_addr_i = 1'b1;
        @(negedge clk);
        chk(bus_rdata_o == 8'hE0, "R9", bus_rdata_o, 8'hE0);
        @(negedge clk);
        chk(bus_rdata_o == 8'hFB, "R9", bus_rdata_o, 8'hFB);

        // R10: mode change after reset is ignored
        do_reset(3'd5);
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h00);
        @(negedge clk);
        mode_i = 3'd7; cs_i = 4'h1;
        repeat (2) @(negedge clk);
        chk(pin_oe_o[4] && pin_o[4] == 1'b1, "R10", {3'b0, pin_o}, 8'h10);
        mode_i = 3'd2;
        repeat (2) @(negedge clk);
        chk(pin_oe_o == 5'h10, "R10", {3'b0, pin_oe_o}, 8'h10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule